// File: doc/BRIEF.md
# Accumulator Machine Datapath

This block is the register-transfer datapath of a 16-bit accumulator computer. It holds the program counter, an address-out register that drives the memory address bus, a data-in register that captures words from memory, and the accumulator. A five-function ALU combines an internal A-bus with the accumulator. A separate control sequencer drives every latch enable and multiplexer select. In return, the datapath hands back the opcode field of the captured word and the accumulator sign.

Memory is byte-addressed and every instruction is one aligned 16-bit word, so the program counter advances by two. The program counter select can load an address from the A-bus and add the step to it in the same cycle. A jump can therefore place the target on the address bus while the counter already points at the instruction after it. The data bus is shared. The datapath drives it only while a write is requested and the sequencer asks for the accumulator to be placed on it.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, the address-out register, the data-in register and the accumulator are all zero, so `mem_addr`, `opcode` and `ac_sign` read 0.
- R2: Each register changes only on a rising clock edge where its own enable (`pc_le`, `ao_le`, `di_le`, `ac_le`) is high. With the enable low it keeps its value whatever the other inputs do.
- R3: On an edge with `ac_le` high, the accumulator takes the ALU result for `alu_fn`. With A the A-bus and B the accumulator: 000 gives A, 001 gives NOT B, 010 gives A AND B, 011 gives A + B modulo 2^16, and 100 gives B shifted right by one with a 0 filled into bit 15. Codes 101 to 111 give 0.
- R4: With `abus_narrow` high, the A-bus carries data-in bits 9..0 zero-extended to 16 bits. With it low, the A-bus carries the whole data-in word.
- R5: On an edge with `pc_le` high, `pc_sel` picks the new PC: 00 gives 0, 01 gives A-bus bits 9..0, 10 gives PC + 2, and 11 gives A-bus bits 9..0 plus 2. All sums are modulo 1024.
- R6: On an edge with `ao_le` high, the address-out register takes the PC when `ao_sel` is 0 and A-bus bits 9..0 when `ao_sel` is 1. `mem_addr` always shows this register.
- R7: On an edge with `di_le` high, the data-in register captures the value present on `mem_data`.
- R8: The datapath drives the accumulator onto `mem_data` only when `drive_ac` is high and `mem_op` is write (10). Otherwise it leaves the bus undriven, so during a read (01) the memory word reaches the data-in register even with `drive_ac` high.
- R9: `opcode` is data-in bits 14..10, and `ac_sign` is accumulator bit 15.
- R10: `mem_cmd` equals `mem_op` in the same cycle (00 idle, 01 read, 10 write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_fn | input | 3 | ALU function code |
| abus_narrow | input | 1 | A-bus carries only the 10-bit address field when high |
| pc_le | input | 1 | PC latch enable |
| pc_sel | input | 2 | PC next-value select |
| ao_le | input | 1 | Address-out latch enable |
| ao_sel | input | 1 | Address-out source: 0 PC, 1 A-bus |
| di_le | input | 1 | Data-in latch enable |
| ac_le | input | 1 | Accumulator latch enable |
| drive_ac | input | 1 | Place accumulator on data bus during a write |
| mem_op | input | 2 | Memory operation from the sequencer |
| opcode | output | 5 | Opcode field of the data-in register |
| ac_sign | output | 1 | Accumulator bit 15 |
| mem_addr | output | 10 | Byte address to memory |
| mem_cmd | output | 2 | Memory operation to memory |
| mem_data | inout | 16 | Shared memory data word |

## Verification
Every register result is due one edge after the enabling control is applied. The bench sets controls just after an edge, advances exactly one edge and samples 1 ns later. The PC and accumulator have no port of their own, so the bench brings them out through the normal path. It copies the PC into the address-out register, which costs one more edge, and it requests a write with `drive_ac` high, which shows the accumulator on `mem_data` in the same cycle. `opcode`, `ac_sign`, `mem_cmd` and the bus drive are combinational and are checked in the cycle their inputs change.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  typedef enum logic [2:0] {
    FN_PASS_A = 3'b000,
    FN_INV_B  = 3'b001,
    FN_AND    = 3'b010,
    FN_ADD    = 3'b011,
    FN_HALF_B = 3'b100
  } alu_fn_e;

  typedef enum logic [1:0] {
    PCS_ZERO      = 2'b00,
    PCS_LOAD      = 2'b01,
    PCS_STEP      = 2'b10,
    PCS_LOAD_STEP = 2'b11
  } pc_src_e;

  typedef enum logic [1:0] {
    MC_IDLE  = 2'b00,
    MC_READ  = 2'b01,
    MC_WRITE = 2'b10
  } mem_cmd_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);

  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [2:0] f, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    case (alu_fn_e'(f))
      FN_PASS_A: alu_eval = a;
      FN_INV_B:  alu_eval = ~b;
      FN_AND:    alu_eval = a & b;
      FN_ADD:    alu_eval = a + b;
      FN_HALF_B: alu_eval = {1'b0, b[DATA_W-1:1]};
      default:   alu_eval = '0;
    endcase
  endfunction

  assign res = alu_eval(fn, opa, opb);

  // R3: shift leaves the top bit clear
  p_half_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_HALF_B) |-> (res[DATA_W-1] == 1'b0));
  // R3: inversion: every bit differs from B
  p_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_INV_B) |-> ((res ^ opb) == {DATA_W{1'b1}}));
  // R3: sum minus B gives back A
  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_ADD) |-> (DATA_W'(res - opb) == opa));

endmodule

// File: rtl/acc_pc.sv
module acc_pc
  import acc_dp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  function automatic logic [ADDR_W-1:0] pc_next(
    input logic [1:0] s, input logic [ADDR_W-1:0] cur, input logic [ADDR_W-1:0] ld);
    case (pc_src_e'(s))
      PCS_ZERO:      pc_next = '0;
      PCS_LOAD:      pc_next = ld;
      PCS_STEP:      pc_next = cur + STEP_V;
      default:       pc_next = ld + STEP_V;
    endcase
  endfunction

  logic [ADDR_W-1:0] pc_d;
  assign pc_d = pc_next(sel, pc, load_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pc <= '0;
    else if (le) pc <= pc_d;
  end

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> $stable(pc));
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (le && sel == PCS_STEP) |=> (pc == ADDR_W'($past(pc) + STEP_V)));
  p_pc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (le && sel == PCS_ZERO) |=> (pc == '0));
  p_pc_ldstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (le && sel == PCS_LOAD_STEP) |=> (pc == ADDR_W'($past(load_val) + STEP_V)));

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ao_le,
  input  logic              ao_sel,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] abus_addr,
  input  logic              di_le,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              ac_le,
  input  logic [DATA_W-1:0] alu_res,
  output logic [ADDR_W-1:0] ao,
  output logic [DATA_W-1:0] di,
  output logic [DATA_W-1:0] ac
);

  logic [ADDR_W-1:0] ao_d;
  assign ao_d = ao_sel ? abus_addr : pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ao <= '0;
    else if (ao_le) ao <= ao_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     di <= '0;
    else if (di_le) di <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ac <= '0;
    else if (ac_le) ac <= alu_res;
  end

  p_ao_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ao_le |=> $stable(ao));
  p_di_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !di_le |=> $stable(di));
  p_ac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_le |=> $stable(ac));
  p_ao_from_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_le && !ao_sel) |=> (ao == $past(pc)));
  p_di_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    di_le |=> (di == $past(bus_in)));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int CMD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        alu_fn,
  input  logic              abus_narrow,
  input  logic              pc_le,
  input  logic [1:0]        pc_sel,
  input  logic              ao_le,
  input  logic              ao_sel,
  input  logic              di_le,
  input  logic              ac_le,
  input  logic              drive_ac,
  input  logic [CMD_W-1:0]  mem_op,
  output logic [DATA_W-ADDR_W-2:0] opcode,
  output logic              ac_sign,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CMD_W-1:0]  mem_cmd,
  inout  wire  [DATA_W-1:0] mem_data
);

  localparam int STEP    = DATA_W / 8;
  localparam int OPC_LSB = ADDR_W;
  localparam int OPC_MSB = DATA_W - 2;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] ao_q;
  logic [DATA_W-1:0] di_q;
  logic [DATA_W-1:0] ac_q;
  logic [DATA_W-1:0] abus;
  logic [DATA_W-1:0] alu_y;
  logic              bus_drive_en;
  logic [DATA_W-1:0] bus_in;

  assign abus = abus_narrow ? {{(DATA_W-ADDR_W){1'b0}}, di_q[ADDR_W-1:0]} : di_q;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .fn(alu_fn), .opa(abus), .opb(ac_q), .res(alu_y)
  );

  acc_pc #(.ADDR_W(ADDR_W), .STEP(STEP)) u_pc (
    .clk(clk), .rst_n(rst_n), .le(pc_le), .sel(pc_sel),
    .load_val(abus[ADDR_W-1:0]), .pc(pc_q)
  );

  acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ao_le(ao_le), .ao_sel(ao_sel), .pc(pc_q), .abus_addr(abus[ADDR_W-1:0]),
    .di_le(di_le), .bus_in(bus_in), .ac_le(ac_le), .alu_res(alu_y),
    .ao(ao_q), .di(di_q), .ac(ac_q)
  );

  assign bus_drive_en = drive_ac && (mem_op == MC_WRITE);
  assign mem_data     = bus_drive_en ? ac_q : {DATA_W{1'bz}};
  assign bus_in       = mem_data;

  assign mem_cmd  = mem_op;
  assign mem_addr = ao_q;
  assign opcode   = di_q[OPC_MSB:OPC_LSB];
  assign ac_sign  = ac_q[DATA_W-1];

  // R8: the bus is only ever driven for a write
  p_drive_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (mem_cmd == MC_WRITE));
  // R8: while driving, the bus carries the accumulator
  p_drive_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (bus_in == ac_q));
  // R6: the address bus follows the address-out register one edge after a load
  p_addr_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_le && ao_sel) |=> (mem_addr == $past(abus[ADDR_W-1:0])));

endmodule

// File: tb/test_acc_datapath.sv
`timescale 1ns/1ps
module test_acc_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  alu_fn;
  logic        abus_narrow, pc_le, ao_le, ao_sel, di_le, ac_le, drive_ac;
  logic [1:0]  pc_sel, mem_op;
  logic [4:0]  opcode;
  logic        ac_sign;
  logic [9:0]  mem_addr;
  logic [1:0]  mem_cmd;
  wire  [15:0] mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  mem [0:1023];
  logic [15:0] rd_word;

  always #2 clk = ~clk;

  acc_datapath i_acc_datapath (
    .clk(clk), .rst_n(rst_n), .alu_fn(alu_fn), .abus_narrow(abus_narrow),
    .pc_le(pc_le), .pc_sel(pc_sel), .ao_le(ao_le), .ao_sel(ao_sel),
    .di_le(di_le), .ac_le(ac_le), .drive_ac(drive_ac), .mem_op(mem_op),
    .opcode(opcode), .ac_sign(ac_sign), .mem_addr(mem_addr),
    .mem_cmd(mem_cmd), .mem_data(mem_data)
  );

  // byte memory, aligned little-endian words, combinational read
  assign rd_word  = {mem[{mem_addr[9:1], 1'b1}], mem[{mem_addr[9:1], 1'b0}]};
  assign mem_data = (mem_cmd == 2'b01) ? rd_word : 16'bz;

  always @(posedge clk) begin
    if (mem_cmd == 2'b10) begin
      mem[{mem_addr[9:1], 1'b0}] <= mem_data[7:0];
      mem[{mem_addr[9:1], 1'b1}] <= mem_data[15:8];
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alu_fn = 3'b000; abus_narrow = 0; pc_le = 0; pc_sel = 2'b00;
    ao_le = 0; ao_sel = 0; di_le = 0; ac_le = 0; drive_ac = 0; mem_op = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic poke(input logic [15:0] w);
    mem[{mem_addr[9:1], 1'b0}] = w[7:0];
    mem[{mem_addr[9:1], 1'b1}] = w[15:8];
  endtask

  function automatic logic [15:0] peek_mem();
    return {mem[{mem_addr[9:1], 1'b1}], mem[{mem_addr[9:1], 1'b0}]};
  endfunction

  task automatic set_di(input logic [15:0] w);
    poke(w); mem_op = 2'b01; di_le = 1; tick(); idle();
  endtask

  task automatic set_ac(input logic [15:0] w);
    set_di(w); alu_fn = 3'b000; ac_le = 1; tick(); idle();
  endtask

  task automatic get_ac(output logic [15:0] v);
    mem_op = 2'b10; drive_ac = 1; #1; v = mem_data; idle();
  endtask

  task automatic get_pc(output logic [9:0] v);
    ao_sel = 0; ao_le = 1; tick(); v = mem_addr; idle();
  endtask

  function automatic logic [15:0] model(input logic [2:0] f, input logic [15:0] a,
                                        input logic [15:0] b);
    int unsigned s;
    case (f)
      3'd0: return a;
      3'd1: return 16'hFFFF - b;
      3'd2: begin
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = a[i] && b[i];
        return r;
      end
      3'd3: begin s = (int'(a) + int'(b)) % 65536; return s[15:0]; end
      3'd4: return b / 16'd2;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic t_reset();
    logic [15:0] v; logic [9:0] p;
    check("R1", "mem_addr", 32'(mem_addr), 0);
    check("R1", "opcode", 32'(opcode), 0);
    check("R1", "ac_sign", 32'(ac_sign), 0);
    get_ac(v);
    check("R1", "ac", 32'(v), 0);
    get_pc(p);
    check("R1", "pc", 32'(p), 0);
  endtask

  task automatic alu_case(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] v;
    set_ac(b); set_di(a);
    alu_fn = f; ac_le = 1; tick(); idle();
    get_ac(v);
    check("R3", $sformatf("alu fn %0d", f), 32'(v), 32'(model(f, a, b)));
  endtask

  task automatic t_alu();
    alu_case(3'd0, 16'h1234, 16'hABCD);
    alu_case(3'd1, 16'h0F0F, 16'h5AA5);
    alu_case(3'd2, 16'hF0F0, 16'h3C3C);
    alu_case(3'd3, 16'h1111, 16'h2222);
    alu_case(3'd3, 16'h0002, 16'hFFFF);
    alu_case(3'd4, 16'h0000, 16'h8001);
    alu_case(3'd4, 16'hFFFF, 16'hFFFF);
    alu_case(3'd5, 16'h1234, 16'h5678);
    alu_case(3'd7, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_abus();
    logic [15:0] v;
    set_di(16'hFC05);
    abus_narrow = 1; ac_le = 1; tick(); idle();
    get_ac(v);
    check("R4", "narrow a-bus", 32'(v), 32'h0005);
    abus_narrow = 0; ac_le = 1; tick(); idle();
    get_ac(v);
    check("R4", "full a-bus", 32'(v), 32'hFC05);
  endtask

  task automatic t_pc();
    logic [9:0] p;
    pc_le = 1; pc_sel = 2'b00; tick(); idle();
    get_pc(p); check("R5", "pc zero", 32'(p), 0);
    pc_le = 1; pc_sel = 2'b10; tick(); tick(); idle();
    get_pc(p); check("R5", "pc step x2", 32'(p), 4);
    set_di(16'h03A6);
    abus_narrow = 1; pc_le = 1; pc_sel = 2'b01; tick(); idle();
    get_pc(p); check("R5", "pc load", 32'(p), 32'h3A6);
    set_di(16'h7FFE);
    abus_narrow = 1; pc_le = 1; pc_sel = 2'b11; tick(); idle();
    get_pc(p); check("R5", "pc load+2 wraps", 32'(p), 0);
    // jump-like: address out gets X, PC gets X+2 in one edge
    set_di(16'h0120);
    abus_narrow = 1; pc_le = 1; pc_sel = 2'b11; ao_le = 1; ao_sel = 1; tick(); idle();
    check("R6", "ao from a-bus", 32'(mem_addr), 32'h120);
    get_pc(p); check("R5", "pc after jump", 32'(p), 32'h122);
  endtask

  task automatic t_hold();
    logic [15:0] v; logic [9:0] p, a0;
    set_di(16'h2C00);
    poke(16'h7C00); mem_op = 2'b01; di_le = 0; tick(); idle();
    check("R2", "di hold (opcode)", 32'(opcode), 32'h0B);
    set_ac(16'h1111);
    alu_fn = 3'd3; ac_le = 0; tick(); idle();
    get_ac(v); check("R2", "ac hold", 32'(v), 32'h1111);
    get_pc(p);
    pc_le = 0; pc_sel = 2'b10; tick(); idle();
    get_pc(a0); check("R2", "pc hold", 32'(a0), 32'(p));
    set_di(16'h0155);
    a0 = mem_addr;
    abus_narrow = 1; ao_sel = 1; ao_le = 0; tick(); idle();
    check("R2", "ao hold", 32'(mem_addr), 32'(a0));
  endtask

  task automatic t_di();
    set_di(16'hB7C3);
    check("R7", "opcode after capture", 32'(opcode), 32'((16'hB7C3 >> 10) & 16'h1F));
    set_di(16'h7C00);
    check("R9", "opcode all ones", 32'(opcode), 32'h1F);
  endtask

  task automatic t_bus();
    logic [15:0] v;
    set_ac(16'h5A3C);
    mem_op = 2'b10; drive_ac = 1; tick(); idle();
    check("R8", "write stores ac", 32'(peek_mem()), 32'h5A3C);
    set_ac(16'hFFFF);
    poke(16'h1234);
    mem_op = 2'b01; drive_ac = 1; di_le = 1; tick(); idle();
    alu_fn = 3'd0; ac_le = 1; tick(); idle();
    get_ac(v);
    check("R8", "read not disturbed by drive_ac", 32'(v), 32'h1234);
  endtask

  task automatic t_sign();
    set_ac(16'h8000);
    check("R9", "sign set", 32'(ac_sign), 1);
    set_ac(16'h7FFF);
    check("R9", "sign clear", 32'(ac_sign), 0);
  endtask

  task automatic t_cmd();
    mem_op = 2'b01; #1; check("R10", "cmd read", 32'(mem_cmd), 1);
    mem_op = 2'b10; #1; check("R10", "cmd write", 32'(mem_cmd), 2);
    mem_op = 2'b00; #1; check("R10", "cmd idle", 32'(mem_cmd), 0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_alu();
    t_abus();
    t_pc();
    t_hold();
    t_di();
    t_bus();
    t_sign();
    t_cmd();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule